// File: doc/BRIEF.md
# Register-Indexed Cache Access Memo

This block keeps one small record per architectural register describing where the address held in that register lives in the memory system: its physical page number, its L1 data-cache set, the cache way holding its line, and two knowledge flags. One flag says the translation (page number) is known. The other says the line is resident and its way is known. With 32 registers, a 32 KB 4-way cache, 64-byte lines and 8 KB pages, a record carries a 19-bit page number, a 7-bit set index and a 2-bit way.

An address-preparing operation computes a new address from a source register into a destination register. The upstream adder reports whether the new address stays within the source's line or page. The memo then fills the destination record by copying forward whatever the source record already knows. A load or store names the register that holds its address, and one cycle later the block answers with the access class. The class is one of three: a direct access to a single known data way with no TLB and no tag lookup, a tag check with a known page and no TLB lookup, or a full lookup. When the way is unknown the block raises a lookup request. The result of that lookup is written back into the record through a fill port.

Plain register writes make a record unknown. Line eviction or replacement clears way knowledge in every record that points at the affected line, all 32 records in one cycle.

Top module: `memo_table`

## Requirements
- R1: Reset makes every record unknown. In the cycle after reset no response is valid, and a read of any register then returns class FULL.
- R2: Each cycle with `rd_vld` high produces exactly one response with `rsp_vld` high in the following cycle. No response appears otherwise.
- R3: `rsp_mode` is encoded as 0 = FULL, 1 = TAG (page known, way unknown) and 2 = DIRECT (page and way known). `rsp_ppn` is zero in class FULL and `rsp_way` is zero unless the class is DIRECT. `lookup_req` is high exactly when `rsp_vld` is high and the class is not DIRECT.
- R4: A fill writes the given page number, set and way into the named record and marks both page and way known.
- R5: An ordinary register write (`gwr_vld`) makes the named record unknown in both respects.
- R6: A prepare operation flagged as staying in the source's line, whose source record has its way known, copies page, set and way into the destination record with both flags set.
- R7: Consider a prepare operation that stays within the page, or within the line when the source way is unknown. If its source has a known page, the destination gets the source's page number and the new set from `pam_sidx`, with the page known and the way unknown.
- R8: Any other prepare operation makes the destination record unknown in both respects.
- R9: An invalidate clears way knowledge, and keeps page knowledge, in every record whose way is known and whose page number and set both equal the invalidate's. All other records are unchanged.
- R10: A read in the same cycle as a write to the same register reports the newly written record.
- R11: When several writes name one register in a cycle, the ordinary register write wins over a prepare, and a prepare wins over a fill.
- R12: A prepare reads its source record after any invalidate applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pam_vld | input | 1 | Prepare operation valid |
| pam_dst | input | 5 | Destination register of the prepare |
| pam_src | input | 5 | Source register of the prepare |
| pam_same_line | input | 1 | New address lies in the source's line |
| pam_same_page | input | 1 | New address lies in the source's page |
| pam_sidx | input | 7 | Set index of the new address |
| fill_vld | input | 1 | Full-lookup result write-back valid |
| fill_reg | input | 5 | Register whose record is filled |
| fill_ppn | input | 19 | Physical page number from the lookup |
| fill_sidx | input | 7 | Set index from the lookup |
| fill_way | input | 2 | Way holding the line |
| gwr_vld | input | 1 | Ordinary register write valid |
| gwr_reg | input | 5 | Register being written |
| inv_vld | input | 1 | Line eviction/replacement notice valid |
| inv_ppn | input | 19 | Page number of the removed line |
| inv_sidx | input | 7 | Set index of the removed line |
| rd_vld | input | 1 | Load/store record read valid |
| rd_reg | input | 5 | Register holding the access address |
| rsp_vld | output | 1 | Response valid |
| rsp_mode | output | 2 | Access class (0 FULL, 1 TAG, 2 DIRECT) |
| rsp_ppn | output | 19 | Known physical page number |
| rsp_way | output | 2 | Known way |
| lookup_req | output | 1 | Full or tag lookup required |

## Verification
A corrupted record only shows through a later read of that register. The read's response one cycle later then carries a wrong class, page or way, and `lookup_req` disagrees. A stale flag after an invalidate shows up as DIRECT where TAG is due, for every register that copied the line forward. A broken copy-forward shows up on the destination register's next read. A wrong write priority or missing forwarding shows up in the very next response, because the response reflects the record as updated in the read's own cycle.

// File: rtl/memo_pkg.sv
package memo_pkg;

    localparam int NUM_REGS   = 32;
    localparam int ADDR_W     = 32;
    localparam int PAGE_BYTES = 8192;
    localparam int LINE_BYTES = 64;
    localparam int DC_BYTES   = 32768;
    localparam int DC_WAYS    = 4;

    localparam int REG_W      = $clog2(NUM_REGS);
    localparam int PG_OFS_W   = $clog2(PAGE_BYTES);
    localparam int LINE_OFS_W = $clog2(LINE_BYTES);
    localparam int WAY_W      = $clog2(DC_WAYS);
    localparam int SET_W      = $clog2(DC_BYTES / DC_WAYS) - LINE_OFS_W;
    localparam int PPN_W      = ADDR_W - PG_OFS_W;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [SET_W-1:0] sidx_t;
    typedef logic [WAY_W-1:0] way_t;

    typedef enum logic [1:0] {
        ACC_FULL   = 2'd0,
        ACC_TAG    = 2'd1,
        ACC_DIRECT = 2'd2
    } acc_mode_e;

    typedef struct packed {
        ppn_t  ppn;
        sidx_t sidx;
        way_t  way;
        logic  line_ok;
        logic  xlat_ok;
    } memo_ent_t;

    localparam memo_ent_t ENT_EMPTY = '0;

    function automatic acc_mode_e mode_of(memo_ent_t e);
        if (e.line_ok && e.xlat_ok) return ACC_DIRECT;
        if (e.xlat_ok)              return ACC_TAG;
        return ACC_FULL;
    endfunction

    function automatic logic line_match(memo_ent_t e, ppn_t p, sidx_t s);
        return e.line_ok && (e.ppn == p) && (e.sidx == s);
    endfunction

    function automatic memo_ent_t prep_result(memo_ent_t src, logic same_line,
                                              logic same_page, sidx_t new_sidx);
        memo_ent_t r;
        r = ENT_EMPTY;
        if (same_line && src.line_ok && src.xlat_ok) begin
            r = src;
        end else if ((same_line || same_page) && src.xlat_ok) begin
            r.ppn     = src.ppn;
            r.sidx    = new_sidx;
            r.xlat_ok = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/memo_slot.sv
module memo_slot
    import memo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      inv_vld,
    input  ppn_t      inv_ppn,
    input  sidx_t     inv_sidx,
    input  logic      wr_en,
    input  memo_ent_t wr_ent,
    output memo_ent_t cln,
    output memo_ent_t nxt
);

    memo_ent_t q;

    // Invalidate acts on the stored record; any write then replaces it.
    always_comb begin
        cln = q;
        if (inv_vld && line_match(q, inv_ppn, inv_sidx)) begin
            cln.line_ok = 1'b0;
        end
        nxt = wr_en ? wr_ent : cln;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ENT_EMPTY;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/memo_prep.sv
module memo_prep
    import memo_pkg::*;
(
    input  memo_ent_t cln [NUM_REGS],
    input  reg_idx_t  pam_src,
    input  logic      pam_same_line,
    input  logic      pam_same_page,
    input  sidx_t     pam_sidx,
    output memo_ent_t prep_ent
);

    always_comb begin
        prep_ent = prep_result(cln[pam_src], pam_same_line, pam_same_page, pam_sidx);
    end

endmodule

// File: rtl/memo_rsp.sv
module memo_rsp
    import memo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  memo_ent_t nxt [NUM_REGS],
    input  logic      rd_vld,
    input  reg_idx_t  rd_reg,
    output logic      rsp_vld,
    output acc_mode_e rsp_mode,
    output ppn_t      rsp_ppn,
    output way_t      rsp_way,
    output logic      lookup_req
);

    memo_ent_t sel;
    acc_mode_e sel_mode;

    always_comb begin
        sel      = nxt[rd_reg];
        sel_mode = mode_of(sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld    <= 1'b0;
            rsp_mode   <= ACC_FULL;
            rsp_ppn    <= '0;
            rsp_way    <= '0;
            lookup_req <= 1'b0;
        end else begin
            rsp_vld    <= rd_vld;
            rsp_mode   <= rd_vld ? sel_mode : ACC_FULL;
            rsp_ppn    <= (rd_vld && sel_mode != ACC_FULL) ? sel.ppn : '0;
            rsp_way    <= (rd_vld && sel_mode == ACC_DIRECT) ? sel.way : '0;
            lookup_req <= rd_vld && (sel_mode != ACC_DIRECT);
        end
    end

endmodule

// File: rtl/memo_table.sv
module memo_table
    import memo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pam_vld,
    input  logic [REG_W-1:0]      pam_dst,
    input  logic [REG_W-1:0]      pam_src,
    input  logic                  pam_same_line,
    input  logic                  pam_same_page,
    input  logic [SET_W-1:0]      pam_sidx,
    input  logic                  fill_vld,
    input  logic [REG_W-1:0]      fill_reg,
    input  logic [PPN_W-1:0]      fill_ppn,
    input  logic [SET_W-1:0]      fill_sidx,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic                  gwr_vld,
    input  logic [REG_W-1:0]      gwr_reg,
    input  logic                  inv_vld,
    input  logic [PPN_W-1:0]      inv_ppn,
    input  logic [SET_W-1:0]      inv_sidx,
    input  logic                  rd_vld,
    input  logic [REG_W-1:0]      rd_reg,
    output logic                  rsp_vld,
    output logic [1:0]            rsp_mode,
    output logic [PPN_W-1:0]      rsp_ppn,
    output logic [WAY_W-1:0]      rsp_way,
    output logic                  lookup_req
);

    memo_ent_t cln_a [NUM_REGS];
    memo_ent_t nxt_a [NUM_REGS];
    memo_ent_t prep_ent;
    memo_ent_t fill_ent;
    acc_mode_e mode_q;

    always_comb begin
        fill_ent         = ENT_EMPTY;
        fill_ent.ppn     = fill_ppn;
        fill_ent.sidx    = fill_sidx;
        fill_ent.way     = fill_way;
        fill_ent.line_ok = 1'b1;
        fill_ent.xlat_ok = 1'b1;
    end

    memo_prep u_prep (
        .cln           (cln_a),
        .pam_src       (pam_src),
        .pam_same_line (pam_same_line),
        .pam_same_page (pam_same_page),
        .pam_sidx      (pam_sidx),
        .prep_ent      (prep_ent)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        logic      hit_g;
        logic      hit_p;
        logic      hit_f;
        logic      wr_en;
        memo_ent_t wr_ent;

        assign hit_g  = gwr_vld  && (gwr_reg  == REG_W'(i));
        assign hit_p  = pam_vld  && (pam_dst  == REG_W'(i));
        assign hit_f  = fill_vld && (fill_reg == REG_W'(i));
        assign wr_en  = hit_g || hit_p || hit_f;
        assign wr_ent = hit_g ? ENT_EMPTY : (hit_p ? prep_ent : fill_ent);

        memo_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .inv_vld  (inv_vld),
            .inv_ppn  (inv_ppn),
            .inv_sidx (inv_sidx),
            .wr_en    (wr_en),
            .wr_ent   (wr_ent),
            .cln      (cln_a[i]),
            .nxt      (nxt_a[i])
        );
    end

    memo_rsp u_rsp (
        .clk        (clk),
        .rst        (rst),
        .nxt        (nxt_a),
        .rd_vld     (rd_vld),
        .rd_reg     (rd_reg),
        .rsp_vld    (rsp_vld),
        .rsp_mode   (mode_q),
        .rsp_ppn    (rsp_ppn),
        .rsp_way    (rsp_way),
        .lookup_req (lookup_req)
    );

    assign rsp_mode = mode_q;

endmodule

// File: rtl/memo_table_chk.sv
module memo_table_chk
    import memo_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pam_vld,
    input logic [REG_W-1:0] pam_dst,
    input logic             pam_same_line,
    input logic             pam_same_page,
    input logic             fill_vld,
    input logic [REG_W-1:0] fill_reg,
    input logic [PPN_W-1:0] fill_ppn,
    input logic [WAY_W-1:0] fill_way,
    input logic             gwr_vld,
    input logic [REG_W-1:0] gwr_reg,
    input logic             rd_vld,
    input logic [REG_W-1:0] rd_reg,
    input logic             rsp_vld,
    input logic [1:0]       rsp_mode,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic [WAY_W-1:0] rsp_way,
    input logic             lookup_req
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_vld && !lookup_req));

    // R2
    rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_vld |=> rsp_vld);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_vld |=> !rsp_vld);

    // R3
    lookup_when_unknown_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_mode != 2'd2) |-> lookup_req);

    // R3
    no_lookup_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_mode == 2'd2 || !rsp_vld) |-> !lookup_req);

    // R3
    full_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_mode == 2'd0) |-> (rsp_ppn == '0 && rsp_way == '0));

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_mode != 2'd3);

    // R4 R10
    fill_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_vld && rd_vld && rd_reg == fill_reg
         && !(gwr_vld && gwr_reg == fill_reg)
         && !(pam_vld && pam_dst == fill_reg))
        |=> (rsp_mode == 2'd2 && rsp_ppn == $past(fill_ppn) && rsp_way == $past(fill_way)));

    // R5 R11
    gwr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (gwr_vld && rd_vld && rd_reg == gwr_reg) |=> (rsp_mode == 2'd0));

    // R8
    pam_unrelated_chk: assert property (@(posedge clk) disable iff (rst)
        (pam_vld && !pam_same_line && !pam_same_page && rd_vld && rd_reg == pam_dst
         && !(gwr_vld && gwr_reg == pam_dst))
        |=> (rsp_mode == 2'd0));

endmodule

bind memo_table memo_table_chk i_chk (.*);

// File: tb/test_memo_table.sv
module test_memo_table;
    import memo_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pam_vld = 1'b0, pam_same_line = 1'b0, pam_same_page = 1'b0;
    logic [REG_W-1:0] pam_dst = '0, pam_src = '0;
    logic [SET_W-1:0] pam_sidx = '0;
    logic             fill_vld = 1'b0;
    logic [REG_W-1:0] fill_reg = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [SET_W-1:0] fill_sidx = '0;
    logic [WAY_W-1:0] fill_way = '0;
    logic             gwr_vld = 1'b0;
    logic [REG_W-1:0] gwr_reg = '0;
    logic             inv_vld = 1'b0;
    logic [PPN_W-1:0] inv_ppn = '0;
    logic [SET_W-1:0] inv_sidx = '0;
    logic             rd_vld = 1'b0;
    logic [REG_W-1:0] rd_reg = '0;
    logic             rsp_vld, lookup_req;
    logic [1:0]       rsp_mode;
    logic [PPN_W-1:0] rsp_ppn;
    logic [WAY_W-1:0] rsp_way;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]       mode;
        logic [PPN_W-1:0] ppn;
        logic [WAY_W-1:0] way;
        string            tag;
    } exp_t;
    exp_t sb [$];

    always #10 clk = ~clk;

    memo_table i_memo_table (.*);

    task automatic idle();
        pam_vld = 1'b0; fill_vld = 1'b0; gwr_vld = 1'b0; inv_vld = 1'b0; rd_vld = 1'b0;
        pam_same_line = 1'b0; pam_same_page = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic do_fill(int r, int p, int s, int w);
        fill_vld = 1'b1; fill_reg = REG_W'(r); fill_ppn = PPN_W'(p);
        fill_sidx = SET_W'(s); fill_way = WAY_W'(w);
    endtask

    task automatic do_pam(int d, int s, bit ln, bit pg, int sx);
        pam_vld = 1'b1; pam_dst = REG_W'(d); pam_src = REG_W'(s);
        pam_same_line = ln; pam_same_page = pg; pam_sidx = SET_W'(sx);
    endtask

    task automatic do_inv(int p, int s);
        inv_vld = 1'b1; inv_ppn = PPN_W'(p); inv_sidx = SET_W'(s);
    endtask

    task automatic do_gwr(int r);
        gwr_vld = 1'b1; gwr_reg = REG_W'(r);
    endtask

    task automatic exp_rd(int r, acc_mode_e m, int p, int w, string tag);
        exp_t e;
        rd_vld = 1'b1; rd_reg = REG_W'(r);
        e.mode = m; e.ppn = PPN_W'(p); e.way = WAY_W'(w); e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares each response against the oldest expected item.
    always @(negedge clk) begin
        if (!rst && rsp_vld && !done) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2: response with nothing expected (got rsp_vld=1, expected 0)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_mode !== e.mode || rsp_ppn !== e.ppn || rsp_way !== e.way
                    || lookup_req !== (e.mode != 2'd2)) begin
                    bad++;
                    $display("FAIL %s: got mode=%0d ppn=%h way=%0d req=%0b, expected mode=%0d ppn=%h way=%0d req=%0b",
                             e.tag, rsp_mode, rsp_ppn, rsp_way, lookup_req,
                             e.mode, e.ppn, e.way, (e.mode != 2'd2));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete (got hang, expected finish)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (rsp_vld !== 1'b0 || lookup_req !== 1'b0) begin
            bad++;
            $display("FAIL R1: got rsp_vld=%0b req=%0b, expected 0 0", rsp_vld, lookup_req);
        end

        // R1: unknown after reset
        exp_rd(5, ACC_FULL, 0, 0, "R1"); tick();
        exp_rd(31, ACC_FULL, 0, 0, "R1"); tick();

        // R4: fill then read
        do_fill(3, 'h12345, 'h21, 2); tick();
        exp_rd(3, ACC_DIRECT, 'h12345, 2, "R4"); tick();

        // R6: same line copy-forward
        do_pam(4, 3, 1, 1, 'h21); tick();
        exp_rd(4, ACC_DIRECT, 'h12345, 2, "R6"); tick();

        // R7: same page only
        do_pam(6, 3, 0, 1, 'h22); tick();
        exp_rd(6, ACC_TAG, 'h12345, 0, "R7"); tick();

        // R8: neither
        do_pam(7, 3, 0, 0, 'h00); tick();
        exp_rd(7, ACC_FULL, 0, 0, "R8"); tick();

        // R7: same line but source way unknown
        do_pam(8, 6, 1, 1, 'h22); tick();
        exp_rd(8, ACC_TAG, 'h12345, 0, "R7"); tick();

        // R8: source with nothing known
        do_pam(20, 5, 0, 1, 'h01); tick();
        exp_rd(20, ACC_FULL, 0, 0, "R8"); tick();

        // R9: invalidate one line
        do_fill(9, 'h12345, 'h30, 1); tick();
        do_fill(10, 'h00777, 'h21, 3); tick();
        do_inv('h12345, 'h21); tick();
        exp_rd(3, ACC_TAG, 'h12345, 0, "R9"); tick();
        exp_rd(4, ACC_TAG, 'h12345, 0, "R9"); tick();
        exp_rd(9, ACC_DIRECT, 'h12345, 1, "R9"); tick();
        exp_rd(10, ACC_DIRECT, 'h00777, 3, "R9"); tick();

        // R5: ordinary write clears
        do_gwr(9); tick();
        exp_rd(9, ACC_FULL, 0, 0, "R5"); tick();

        // R10: same-cycle forwarding
        do_fill(11, 'h04000, 'h7F, 0); exp_rd(11, ACC_DIRECT, 'h04000, 0, "R10"); tick();
        do_gwr(10); exp_rd(10, ACC_FULL, 0, 0, "R10"); tick();

        // R11: priority
        do_fill(12, 'h00001, 'h01, 1); do_pam(12, 11, 1, 1, 'h7F); tick();
        exp_rd(12, ACC_DIRECT, 'h04000, 0, "R11"); tick();
        do_gwr(12); do_fill(12, 'h00002, 'h02, 2); do_pam(12, 11, 1, 1, 'h7F); tick();
        exp_rd(12, ACC_FULL, 0, 0, "R11"); tick();

        // R12: prepare sees same-cycle invalidate of its source
        do_fill(13, 'h05555, 'h10, 3); tick();
        do_inv('h05555, 'h10); do_pam(14, 13, 1, 1, 'h10); tick();
        exp_rd(14, ACC_TAG, 'h05555, 0, "R12"); tick();
        exp_rd(13, ACC_TAG, 'h05555, 0, "R9"); tick();

        tick(); tick();
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2: got %0d responses missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule